// File: doc/BRIEF.md
# Addressing Mode Operand Access Unit

This block resolves the operand of one instruction for an 8-bit processor core. The sequencer hands it an addressing mode, up to two operand bytes, the X and Y index registers, the accumulator value and, for stores, the byte to write, and pulses `start`. The unit forms the effective address. For the pointer modes it first fetches a 16-bit pointer over a byte-wide synchronous bus, low byte first and then high byte. It then performs a single data read or write and pulses `done`, with the byte read or an error flag.

The bus is synchronous. A read strobe in one cycle returns its byte on `bus_rdata` in the following cycle. Register-A and literal modes never touch the bus. Modes that only redirect the program counter have no operand to access, so they are refused with `err`, and so is a store to a literal. Address arithmetic differs by mode. Only the page-zero X form wraps within page zero. Every other index or pointer sum is carried in 16 bits.

Top module: `opnd_access_unit`

## Requirements
- R1: Mode 2 (page zero) and mode 14 (page-zero bit-test form) access address `op1`. Mode 3 (page zero plus X) accesses `(op1 + X) mod 256`, so the high address byte is always zero.
- R2: Mode 4 (page zero plus Y) accesses `op1 + Y` computed in 16 bits without wrapping, so 0xF0 + 0x20 gives 0x0110.
- R3: Mode 8 accesses `op2*256 + op1`. Modes 9 and 10 add X and Y respectively to that 16-bit value, modulo 65536.
- R4: Mode 5 (pointer in page zero) reads the pointer low byte at `op1`, then the high byte at `op1 + 1`, formed in 16 bits (op1 = 0xFF gives 0x0100), then accesses the pointer.
- R5: Mode 6 (pre-indexed pointer) reads the pointer bytes at `op1 + X` and `op1 + X + 1`, both 16-bit sums without page-zero wrap, then accesses the pointer.
- R6: Mode 7 (post-indexed pointer) reads the pointer from `op1` and `op1 + 1`, then accesses `pointer + Y` modulo 65536.
- R7: Mode 0 (register A) makes no bus access. A read returns `acc_in`. A write pulses `acc_we` together with `done`, with `acc_wdata` equal to `wdata`.
- R8: Mode 1 (literal) read returns `op1` with no bus access. A write in mode 1 is refused with `err`.
- R9: Modes 11, 12 and 13 (jump and branch forms) and the unused code 15 raise `err` with `done` in the cycle after `start`, and make no bus access.
- R10: `done` is a single-cycle pulse that follows the final data access. A store drives `bus_wdata = wdata` in its one write cycle. `bus_rd` and `bus_wr` are never high together.
- R11: While reset is asserted, and after it is released until the next `start`, `done`, `err`, `bus_rd`, `bus_wr` and `acc_we` are low. Asserting reset in the middle of an operation abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operand access; sampled only while idle |
| mode | input | 4 | Addressing mode code (see requirements) |
| wr_en | input | 1 | 1 = write the operand, 0 = read it |
| op1 | input | 8 | First operand byte |
| op2 | input | 8 | Second operand byte (high address byte) |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| acc_in | input | 8 | Current accumulator value |
| wdata | input | 8 | Byte to store |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Read data, valid the cycle after `bus_rd` |
| rd_data | output | 8 | Operand byte read, valid with `done` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Access refused, valid with `done` |
| acc_we | output | 1 | Accumulator write enable (register-A stores) |
| acc_wdata | output | 8 | Accumulator write value |

## Verification
The assertions assume that `start` is honoured only while the unit is idle. They also assume the bus returns read data exactly one cycle after each strobe, so the pointer high-byte fetch always directly follows the low-byte fetch. The bench raises `start` for a single cycle and waits for `done` before it issues the next request. Its bus model is a one-cycle registered read of a computed memory image. Mode and operand inputs are held stable while a request is outstanding, and reset is asserted mid-operation only in the directed test that exercises abandonment.

// File: rtl/oau_pkg.sv
package oau_pkg;
  parameter int DATA_W = 8;
  parameter int ADDR_W = 2 * DATA_W;
  localparam int MODE_W = 4;
  localparam int HI_W   = ADDR_W - DATA_W;

  typedef enum logic [MODE_W-1:0] {
    M_REG_A      = 4'd0,
    M_LIT        = 4'd1,
    M_PAGE0      = 4'd2,
    M_PAGE0_X    = 4'd3,
    M_PAGE0_Y    = 4'd4,
    M_PTR0       = 4'd5,
    M_PTR0_PREX  = 4'd6,
    M_PTR0_POSTY = 4'd7,
    M_FULL       = 4'd8,
    M_FULL_X     = 4'd9,
    M_FULL_Y     = 4'd10,
    M_JMP_IND    = 4'd11,
    M_JMP_IND_X  = 4'd12,
    M_BRANCH     = 4'd13,
    M_PAGE0_BIT  = 4'd14,
    M_RESV       = 4'd15
  } amode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PLO, S_PHI, S_PCAP, S_DATA, S_RCAP, S_FIN
  } st_e;

  function automatic logic [ADDR_W-1:0] zext(input logic [DATA_W-1:0] v);
    return {{HI_W{1'b0}}, v};
  endfunction

  function automatic logic uses_ptr(input amode_e m);
    return (m == M_PTR0) || (m == M_PTR0_PREX) || (m == M_PTR0_POSTY);
  endfunction

  function automatic logic no_bus(input amode_e m);
    return (m == M_REG_A) || (m == M_LIT);
  endfunction

  function automatic logic refused(input amode_e m, input logic wr);
    return (m == M_JMP_IND) || (m == M_JMP_IND_X) || (m == M_BRANCH) ||
           (m == M_RESV) || ((m == M_LIT) && wr);
  endfunction

  // Address of the pointer low byte; 16-bit sum, no page-zero wrap.
  function automatic logic [ADDR_W-1:0] ptr_base(input amode_e m,
                                                 input logic [DATA_W-1:0] b1,
                                                 input logic [DATA_W-1:0] ix);
    return (m == M_PTR0_PREX) ? zext(b1) + zext(ix) : zext(b1);
  endfunction

  // Effective address of the non-pointer memory modes.
  function automatic logic [ADDR_W-1:0] direct_ea(input amode_e m,
                                                  input logic [DATA_W-1:0] b1,
                                                  input logic [DATA_W-1:0] b2,
                                                  input logic [DATA_W-1:0] ix,
                                                  input logic [DATA_W-1:0] iy);
    logic [DATA_W-1:0] wrapped;
    logic [ADDR_W-1:0] full;
    wrapped = b1 + ix;
    full    = {b2, b1};
    case (m)
      M_PAGE0, M_PAGE0_BIT: return zext(b1);
      M_PAGE0_X:            return zext(wrapped);
      M_PAGE0_Y:            return zext(b1) + zext(iy);
      M_FULL:               return full;
      M_FULL_X:             return full + zext(ix);
      M_FULL_Y:             return full + zext(iy);
      default:              return '0;
    endcase
  endfunction

  // Effective address of the pointer modes, once the pointer is known.
  function automatic logic [ADDR_W-1:0] ptr_ea(input amode_e m,
                                               input logic [ADDR_W-1:0] p,
                                               input logic [DATA_W-1:0] iy);
    return (m == M_PTR0_POSTY) ? p + zext(iy) : p;
  endfunction
endpackage

// File: rtl/oau_addr_gen.sv
module oau_addr_gen
  import oau_pkg::*;
(
  input  amode_e            mode,
  input  logic [DATA_W-1:0] op1,
  input  logic [DATA_W-1:0] op2,
  input  logic [DATA_W-1:0] idx_x,
  input  logic [DATA_W-1:0] idx_y,
  input  logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] ptr_lo_addr,
  output logic [ADDR_W-1:0] ptr_hi_addr,
  output logic [ADDR_W-1:0] data_addr
);
  always_comb begin
    ptr_lo_addr = ptr_base(mode, op1, idx_x);
    ptr_hi_addr = ptr_lo_addr + {{(ADDR_W-1){1'b0}}, 1'b1};
    if (uses_ptr(mode)) data_addr = ptr_ea(mode, ptr, idx_y);
    else                data_addr = direct_ea(mode, op1, op2, idx_x, idx_y);
  end
endmodule

// File: rtl/oau_ctrl.sv
module oau_ctrl
  import oau_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] op1,
  input  logic [DATA_W-1:0] op2,
  input  logic [DATA_W-1:0] idx_x,
  input  logic [DATA_W-1:0] idx_y,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [ADDR_W-1:0] ptr_lo_addr,
  input  logic [ADDR_W-1:0] ptr_hi_addr,
  input  logic [ADDR_W-1:0] data_addr,
  output amode_e            cur_mode,
  output logic [DATA_W-1:0] cur_op1,
  output logic [DATA_W-1:0] cur_op2,
  output logic [DATA_W-1:0] cur_x,
  output logic [DATA_W-1:0] cur_y,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              err,
  output logic              acc_we,
  output logic [DATA_W-1:0] acc_wdata,
  output logic              idle,
  output logic              data_phase,
  output logic              ptr_hi_phase
);
  st_e               st;
  logic              wr_q;
  logic              err_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rd_q;
  amode_e            req_mode;

  assign req_mode = amode_e'(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_mode <= M_REG_A;
      cur_op1  <= '0;
      cur_op2  <= '0;
      cur_x    <= '0;
      cur_y    <= '0;
      wr_q     <= 1'b0;
      err_q    <= 1'b0;
      wd_q     <= '0;
      rd_q     <= '0;
      ptr      <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) begin
            cur_mode <= req_mode;
            cur_op1  <= op1;
            cur_op2  <= op2;
            cur_x    <= idx_x;
            cur_y    <= idx_y;
            wr_q     <= wr_en;
            wd_q     <= wdata;
            err_q    <= refused(req_mode, wr_en);
            if (refused(req_mode, wr_en)) begin
              st <= S_FIN;
            end else if (no_bus(req_mode)) begin
              rd_q <= (req_mode == M_LIT) ? op1 : acc_in;
              st   <= S_FIN;
            end else if (uses_ptr(req_mode)) begin
              st <= S_PLO;
            end else begin
              st <= S_DATA;
            end
          end
        end
        S_PLO: st <= S_PHI;
        S_PHI: begin
          ptr[DATA_W-1:0] <= bus_rdata;
          st <= S_PCAP;
        end
        S_PCAP: begin
          ptr[ADDR_W-1:DATA_W] <= bus_rdata;
          st <= S_DATA;
        end
        S_DATA: st <= wr_q ? S_FIN : S_RCAP;
        S_RCAP: begin
          rd_q <= bus_rdata;
          st   <= S_FIN;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_addr = '0;
    case (st)
      S_PLO:   bus_addr = ptr_lo_addr;
      S_PHI:   bus_addr = ptr_hi_addr;
      S_DATA:  bus_addr = data_addr;
      default: bus_addr = '0;
    endcase
  end

  assign data_phase   = (st == S_DATA);
  assign ptr_hi_phase = (st == S_PHI);
  assign idle         = (st == S_IDLE);
  assign bus_rd       = (st == S_PLO) || (st == S_PHI) || (data_phase && !wr_q);
  assign bus_wr       = data_phase && wr_q;
  assign bus_wdata    = wd_q;
  assign done         = (st == S_FIN);
  assign err          = done && err_q;
  assign rd_data      = rd_q;
  assign acc_we       = done && !err_q && wr_q && (cur_mode == M_REG_A);
  assign acc_wdata    = wd_q;
endmodule

// File: rtl/opnd_access_unit.sv
module opnd_access_unit
  import oau_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] op1,
  input  logic [DATA_W-1:0] op2,
  input  logic [DATA_W-1:0] idx_x,
  input  logic [DATA_W-1:0] idx_y,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              err,
  output logic              acc_we,
  output logic [DATA_W-1:0] acc_wdata
);
  amode_e            cur_mode;
  logic [DATA_W-1:0] cur_op1, cur_op2, cur_x, cur_y;
  logic [ADDR_W-1:0] ptr, ptr_lo_addr, ptr_hi_addr, data_addr;
  logic              idle, data_phase, ptr_hi_phase;

  oau_addr_gen u_agen (
    .mode        (cur_mode),
    .op1         (cur_op1),
    .op2         (cur_op2),
    .idx_x       (cur_x),
    .idx_y       (cur_y),
    .ptr         (ptr),
    .ptr_lo_addr (ptr_lo_addr),
    .ptr_hi_addr (ptr_hi_addr),
    .data_addr   (data_addr)
  );

  oau_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .mode         (mode),
    .wr_en        (wr_en),
    .op1          (op1),
    .op2          (op2),
    .idx_x        (idx_x),
    .idx_y        (idx_y),
    .acc_in       (acc_in),
    .wdata        (wdata),
    .bus_rdata    (bus_rdata),
    .ptr_lo_addr  (ptr_lo_addr),
    .ptr_hi_addr  (ptr_hi_addr),
    .data_addr    (data_addr),
    .cur_mode     (cur_mode),
    .cur_op1      (cur_op1),
    .cur_op2      (cur_op2),
    .cur_x        (cur_x),
    .cur_y        (cur_y),
    .ptr          (ptr),
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .rd_data      (rd_data),
    .done         (done),
    .err          (err),
    .acc_we       (acc_we),
    .acc_wdata    (acc_wdata),
    .idle         (idle),
    .data_phase   (data_phase),
    .ptr_hi_phase (ptr_hi_phase)
  );
endmodule

// File: rtl/oau_checker.sv
module oau_checker
  import oau_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [MODE_W-1:0] mode,
  input logic              wr_en,
  input logic              done,
  input logic              err,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              acc_we,
  input logic              idle,
  input logic              data_phase,
  input logic              ptr_hi_phase,
  input amode_e            cur_mode
);
  // R10: read and write strobes are exclusive
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R10: done lasts exactly one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1: page-zero X data access stays inside page zero
  p_zpx_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && cur_mode == M_PAGE0_X) |-> (bus_addr[ADDR_W-1:DATA_W] == '0));

  // R4: pointer high byte is fetched right after the low byte, one address up
  p_ptr_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_hi_phase |-> (bus_rd && $past(bus_rd) &&
                      bus_addr == ADDR_W'($past(bus_addr) + 1'b1)));

  // R9: refused modes finish next cycle with err and no bus traffic
  p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && refused(amode_e'(mode), wr_en)) |=>
      (done && err && !bus_rd && !bus_wr));

  // R7: register-A access finishes next cycle without the bus
  p_acc_nobus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && mode == 4'd0) |=> (done && !err && !bus_rd && !bus_wr));

  // R7: accumulator write only on a successful completion
  p_accwe_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |-> (done && !err));
endmodule

bind opnd_access_unit oau_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .mode         (mode),
  .wr_en        (wr_en),
  .done         (done),
  .err          (err),
  .bus_rd       (bus_rd),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .acc_we       (acc_we),
  .idle         (idle),
  .data_phase   (data_phase),
  .ptr_hi_phase (ptr_hi_phase),
  .cur_mode     (cur_mode)
);

// File: tb/tb_opnd_access_unit.sv
`timescale 1ns/1ps
module tb_opnd_access_unit;
  localparam logic [7:0] ACC_VAL = 8'h3C;
  localparam int NV = 20;
  // {mode, wr, op1, op2, x, y, wdata}
  localparam logic [44:0] VEC [NV] = '{
    {4'd2,  1'b0, 8'h34, 8'h00, 8'h00, 8'h00, 8'h00},
    {4'd3,  1'b0, 8'hF0, 8'h00, 8'h20, 8'h00, 8'h00},
    {4'd4,  1'b0, 8'hF0, 8'h00, 8'h00, 8'h20, 8'h00},
    {4'd8,  1'b0, 8'h34, 8'h12, 8'h00, 8'h00, 8'h00},
    {4'd9,  1'b0, 8'hFF, 8'hFF, 8'h02, 8'h00, 8'h00},
    {4'd10, 1'b0, 8'h80, 8'h12, 8'h00, 8'h90, 8'h00},
    {4'd5,  1'b0, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00},
    {4'd6,  1'b0, 8'hF0, 8'h00, 8'h0F, 8'h00, 8'h00},
    {4'd7,  1'b0, 8'h40, 8'h00, 8'h00, 8'hC0, 8'h00},
    {4'd14, 1'b0, 8'h77, 8'h00, 8'h00, 8'h00, 8'h00},
    {4'd0,  1'b0, 8'h11, 8'h00, 8'h00, 8'h00, 8'h00},
    {4'd1,  1'b0, 8'h9E, 8'h00, 8'h00, 8'h00, 8'h00},
    {4'd1,  1'b1, 8'h9E, 8'h00, 8'h00, 8'h00, 8'h44},
    {4'd11, 1'b0, 8'h00, 8'h30, 8'h00, 8'h00, 8'h00},
    {4'd12, 1'b1, 8'h00, 8'h30, 8'h01, 8'h00, 8'h21},
    {4'd13, 1'b0, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00},
    {4'd15, 1'b0, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00},
    {4'd3,  1'b1, 8'h80, 8'h00, 8'h90, 8'h00, 8'hC3},
    {4'd7,  1'b1, 8'h20, 8'h00, 8'h00, 8'hFF, 8'h6D},
    {4'd0,  1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h5A}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  op1 = '0, op2 = '0, idx_x = '0, idx_y = '0, wdata = '0;
  logic [7:0]  acc_in = ACC_VAL;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr, done, err, acc_we;
  logic [7:0]  bus_wdata, bus_rdata, rd_data, acc_wdata;

  always #4 clk = ~clk;

  opnd_access_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .wr_en(wr_en),
    .op1(op1), .op2(op2), .idx_x(idx_x), .idx_y(idx_y), .acc_in(acc_in),
    .wdata(wdata), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_data(rd_data),
    .done(done), .err(err), .acc_we(acc_we), .acc_wdata(acc_wdata)
  );

  // ---------------- bus model: computed image plus one write slot ---------
  logic        wl_valid = 1'b0;
  logic [15:0] wl_addr = '0;
  logic [7:0]  wl_data = '0;
  logic [7:0]  rdq = '0;
  logic        clr = 1'b0;
  int          nrd = 0, nwr = 0;
  logic [15:0] last_addr = '0;
  logic [7:0]  last_wd = '0;

  function automatic logic [7:0] memv(input logic [15:0] a);
    if (wl_valid && a == wl_addr) return wl_data;
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (bus_rd) rdq <= memv(bus_addr);
    if (bus_wr) begin
      wl_valid <= 1'b1;
      wl_addr  <= bus_addr;
      wl_data  <= bus_wdata;
    end
    if (clr) begin
      nrd = 0; nwr = 0;
    end else begin
      if (bus_rd) begin nrd = nrd + 1; last_addr = bus_addr; end
      if (bus_wr) begin nwr = nwr + 1; last_addr = bus_addr; last_wd = bus_wdata; end
    end
  end
  assign bus_rdata = rdq;

  // ---------------- bookkeeping -------------------------------------------
  int nchk = 0, nerr = 0, cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nerr = nerr + 1;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nerr = nerr + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] m, input logic w);
    case (m)
      4'd0: return "R7";
      4'd1: return w ? "R8" : "R8";
      4'd2, 4'd3, 4'd14: return "R1";
      4'd4: return "R2";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8, 4'd9, 4'd10: return "R3";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [15:0] exp_ea(input logic [3:0] m, input logic [7:0] a,
                                         input logic [7:0] b, input logic [7:0] xx,
                                         input logic [7:0] yy);
    int p, q;
    case (m)
      4'd2, 4'd14: return 16'(a);
      4'd3: return 16'((int'(a) + int'(xx)) % 256);
      4'd4: return 16'(int'(a) + int'(yy));
      4'd8: return 16'(int'(a) + 256 * int'(b));
      4'd9: return 16'((int'(a) + 256 * int'(b) + int'(xx)) % 65536);
      4'd10: return 16'((int'(a) + 256 * int'(b) + int'(yy)) % 65536);
      4'd5, 4'd6, 4'd7: begin
        p = (m == 4'd6) ? int'(a) + int'(xx) : int'(a);
        q = int'(memv(16'(p))) + 256 * int'(memv(16'(p + 1)));
        if (m == 4'd7) q = (q + int'(yy)) % 65536;
        return 16'(q);
      end
      default: return 16'h0;
    endcase
  endfunction

  logic       o_done, o_err, o_accwe;
  logic [7:0] o_rdata, o_accwd;

  task automatic run_op(input logic [3:0] m, input logic w, input logic [7:0] a,
                        input logic [7:0] b, input logic [7:0] xx,
                        input logic [7:0] yy, input logic [7:0] wd);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    mode = m; wr_en = w; op1 = a; op2 = b; idx_x = xx; idx_y = yy; wdata = wd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    o_done = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done) begin
        o_done = 1'b1; o_err = err; o_rdata = rd_data;
        o_accwe = acc_we; o_accwd = acc_wdata;
        break;
      end
      @(negedge clk);
    end
  endtask

  logic [15:0] e_ea;
  logic [7:0]  e_rd;
  logic        e_rej;
  int          e_nrd;

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11", "done in reset", done, 0);
    chk("R11", "bus strobes in reset", {bus_rd, bus_wr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11", "idle outputs after reset", {done, err, bus_rd, bus_wr, acc_we}, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [3:0] m; logic w; logic [7:0] a, b, xx, yy, wd; string t;
      {m, w, a, b, xx, yy, wd} = VEC[v];
      t = tag_of(m, w);
      e_rej = (m == 4'd11) || (m == 4'd12) || (m == 4'd13) || (m == 4'd15) ||
              (m == 4'd1 && w);
      e_ea  = exp_ea(m, a, b, xx, yy);
      e_rd  = memv(e_ea);
      run_op(m, w, a, b, xx, yy, wd);
      chk(t, "done seen", o_done, 1);
      chk(t, "err", o_err, e_rej);
      if (e_rej || m == 4'd0 || m == 4'd1) begin
        chk(t, "bus reads", nrd, 0);
        chk(t, "bus writes", nwr, 0);
        if (!e_rej && m == 4'd0 && w) begin
          chk("R7", "acc_we", o_accwe, 1);
          chk("R7", "acc_wdata", o_accwd, wd);
        end else begin
          chk(t, "acc_we", o_accwe, 0);
        end
        if (!e_rej && !w) chk(t, "rd_data", o_rdata, (m == 4'd0) ? ACC_VAL : a);
      end else begin
        e_nrd = ((m >= 4'd5 && m <= 4'd7) ? 2 : 0) + (w ? 0 : 1);
        chk(t, "bus reads", nrd, e_nrd);
        chk(t, "bus writes", nwr, w ? 1 : 0);
        chk(t, "access address", last_addr, e_ea);
        if (w) chk("R10", "bus_wdata", last_wd, wd);
        else   chk(t, "rd_data", o_rdata, e_rd);
      end
      @(negedge clk);
      chk("R10", "done single pulse", done, 0);
    end

    // directed: store then load back through a full address (R3, R10)
    run_op(4'd8, 1'b1, 8'h22, 8'h22, 8'h00, 8'h00, 8'h77);
    chk("R10", "store address", last_addr, 16'h2222);
    run_op(4'd9, 1'b0, 8'h20, 8'h22, 8'h02, 8'h00, 8'h00);
    chk("R3", "load back stored byte", o_rdata, 8'h77);

    // directed: pointer fetch across the page-zero end, post-indexed (R6)
    e_ea = exp_ea(4'd7, 8'hFF, 8'h00, 8'h00, 8'h80);
    run_op(4'd7, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h80, 8'h00);
    chk("R6", "pointer at 00FF/0100 plus Y", last_addr, e_ea);

    // directed: reset mid-operation (R11)
    @(negedge clk);
    mode = 4'd5; wr_en = 1'b0; op1 = 8'h10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11", "strobes dropped on reset", {bus_rd, bus_wr, done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "no completion after abandoned op", {done, bus_rd}, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule